// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind an I2C bit engine. It watches the bytes that arrive after a START or repeated START and decides whether the local slave is being addressed. The own address is ten bits wide. A mode pin selects either a short address (the low seven bits) or a long address. A long address is matched over two bytes: the first carries a fixed five-bit prefix together with the top two address bits, and the second carries the low eight bits. The reserved general-call byte and the START byte are also recognised, and the block reports them separately from a hit on its unique address.

Received bytes arrive over a valid/ready stream. `byte_ready` is always high, so the producer never sees back-pressure and a byte is consumed on every cycle in which `byte_valid` is high. Bytes that arrive when the block is not waiting for an address byte are consumed and have no effect. START and STOP indications are plain single-cycle pulses. A START has priority over a byte in the same cycle, and a STOP has priority over a byte in the same cycle. The status flags are sticky and clear on a status-read pulse.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `selected`, `match_pulse`, `addr_hit`, `gen_call`, `rw_bit` and `sr_event` are 0. Bytes are ignored until the first `start_i`.
- R2: In short mode (`mode_10b`=0), a first byte whose bits 7:1 equal `own_addr[6:0]` raises `match_pulse` for exactly one cycle, in the cycle after the byte is accepted. In that same cycle, `selected` and `addr_hit` are raised and `gen_call` is 0.
- R3: In either mode, a first byte of 0x00 (general call) or 0x01 (START byte) counts as a match with `gen_call`=1. This match takes priority over a unique-address compare.
- R4: In long mode (`mode_10b`=1), a first byte of {11110, `own_addr[9:8]`, rw} gives no pulse and leaves the block unselected. A second byte equal to `own_addr[7:0]` then raises `match_pulse` and `selected` one cycle after it is accepted.
- R5: If either address byte mismatches, the block stays unselected. All later bytes are ignored until the next `start_i`.
- R6: `rw_bit` takes bit 0 of the first byte after START and holds it for the rest of the transaction.
- R7: `start_i` restarts matching. `selected` is 0 in the cycle after `start_i`.
- R8: `sr_event` pulses in the cycle after `start_i` or `stop_i` only if `selected` was 1 when that input arrived. Otherwise it stays 0.
- R9: `stat_rd` clears `addr_hit` and `gen_call` in the next cycle. A match accepted in the same cycle as `stat_rd` wins, and the flags stay set.
- R10: `byte_ready` is always 1. Bytes accepted while selected produce no pulse and do not change `rw_bit`.
- R11: If `start_i` and `byte_valid` are high in the same cycle, the byte is dropped and the next byte is treated as the first address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START seen (pulse) |
| stop_i | input | 1 | STOP seen (pulse) |
| byte_valid | input | 1 | Received byte present |
| byte_ready | output | 1 | Byte accepted (always 1) |
| byte_data | input | 8 | Received byte |
| own_addr | input | 10 | Own slave address |
| mode_10b | input | 1 | 1 selects long (two-byte) addressing |
| stat_rd | input | 1 | Status read; clears sticky flags |
| match_pulse | output | 1 | One-cycle address match |
| addr_hit | output | 1 | Sticky match flag |
| gen_call | output | 1 | Sticky flag: last match was general call / START byte |
| rw_bit | output | 1 | Captured read/write bit |
| selected | output | 1 | Slave is addressed |
| sr_event | output | 1 | STOP/restart seen while selected (pulse) |

## Verification
Every result is one register stage from its cause. `match_pulse`, `selected`, the flags and `rw_bit` change at the clock edge that accepts the byte. `sr_event` and the drop of `selected` appear at the edge that samples `start_i` or `stop_i`. The bench drives each stimulus at a falling edge, removes it at the next falling edge, and samples the outputs at that moment. It then samples one further falling edge later to confirm that each pulse lasts a single cycle. For the long address, the checks sit after both the first byte and the second byte, which shows that the pulse appears only on the second.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [1:0] {
    AM_IDLE   = 2'd0,
    AM_FIRST  = 2'd1,
    AM_SECOND = 2'd2,
    AM_SEL    = 2'd3
  } am_state_e;

  typedef struct packed {
    logic gc_hit;
    logic uni_hit;
    logic ten_hdr;
  } first_cls_t;

  localparam logic [7:0] GC_CODE = 8'h00;
  localparam logic [7:0] SB_CODE = 8'h01;
  localparam logic [4:0] TEN_PFX = 5'b11110;
endpackage

// File: rtl/i2c_am_first_decode.sv
module i2c_am_first_decode
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              mode_10b,
  output first_cls_t        cls,
  output logic              second_ok
);
  localparam int SHORT_W = BYTE_W - 1;
  localparam int HI_W    = ADDR_W - BYTE_W;
  localparam int PFX_W   = SHORT_W - HI_W;

  logic [SHORT_W-1:0] addr_field;
  logic [SHORT_W-1:0] long_hdr;
  logic [PFX_W-1:0]   pfx;

  assign addr_field = byte_in[BYTE_W-1:1];
  assign pfx        = TEN_PFX[PFX_W-1:0];
  assign long_hdr   = {pfx, own_addr[ADDR_W-1:BYTE_W]};

  always_comb begin
    cls.gc_hit  = (byte_in == GC_CODE[BYTE_W-1:0]) || (byte_in == SB_CODE[BYTE_W-1:0]);
    cls.uni_hit = !mode_10b && (addr_field == own_addr[SHORT_W-1:0]);
    cls.ten_hdr = mode_10b && (addr_field == long_hdr);
  end

  assign second_ok = (byte_in == own_addr[BYTE_W-1:0]);
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
  import i2c_am_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       take,
  input  first_cls_t cls,
  input  logic       second_ok,
  output logic       set_hit,
  output logic       set_gc,
  output logic       cap_rw,
  output logic       match_q,
  output logic       sel_q,
  output logic       sr_q
);
  am_state_e state, state_nx;
  logic      byte_go;
  logic      first_hit;

  assign byte_go   = take && !start_i && !stop_i;
  assign first_hit = cls.gc_hit || cls.uni_hit;
  assign cap_rw    = byte_go && (state == AM_FIRST);
  assign set_gc    = cap_rw && cls.gc_hit;
  assign set_hit   = (cap_rw && first_hit) ||
                     (byte_go && (state == AM_SECOND) && second_ok);

  always_comb begin
    state_nx = state;
    if (start_i) begin
      state_nx = AM_FIRST;
    end else if (stop_i) begin
      state_nx = AM_IDLE;
    end else if (take) begin
      unique case (state)
        AM_FIRST: begin
          if (first_hit)        state_nx = AM_SEL;
          else if (cls.ten_hdr) state_nx = AM_SECOND;
          else                  state_nx = AM_IDLE;
        end
        AM_SECOND: state_nx = second_ok ? AM_SEL : AM_IDLE;
        default:   state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= AM_IDLE;
      match_q <= 1'b0;
      sr_q    <= 1'b0;
    end else begin
      state   <= state_nx;
      match_q <= set_hit;
      sr_q    <= (start_i || stop_i) && (state == AM_SEL);
    end
  end

  assign sel_q = (state == AM_SEL);
endmodule

// File: rtl/i2c_am_flags.sv
module i2c_am_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_hit,
  input  logic set_gc,
  input  logic cap_rw,
  input  logic rw_in,
  input  logic clr,
  output logic hit_q,
  output logic gc_q,
  output logic rw_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      gc_q  <= 1'b0;
      rw_q  <= 1'b0;
    end else begin
      if (set_hit) begin
        hit_q <= 1'b1;
        gc_q  <= set_gc;
      end else if (clr) begin
        hit_q <= 1'b0;
        gc_q  <= 1'b0;
      end
      if (cap_rw) rw_q <= rw_in;
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              mode_10b,
  input  logic              stat_rd,
  output logic              match_pulse,
  output logic              addr_hit,
  output logic              gen_call,
  output logic              rw_bit,
  output logic              selected,
  output logic              sr_event
);
  first_cls_t cls;
  logic       second_ok;
  logic       take;
  logic       set_hit, set_gc, cap_rw;

  assign byte_ready = 1'b1;
  assign take       = byte_valid && byte_ready;

  i2c_am_first_decode #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dec (
    .byte_in   (byte_data),
    .own_addr  (own_addr),
    .mode_10b  (mode_10b),
    .cls       (cls),
    .second_ok (second_ok)
  );

  i2c_am_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .take      (take),
    .cls       (cls),
    .second_ok (second_ok),
    .set_hit   (set_hit),
    .set_gc    (set_gc),
    .cap_rw    (cap_rw),
    .match_q   (match_pulse),
    .sel_q     (selected),
    .sr_q      (sr_event)
  );

  i2c_am_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_hit (set_hit),
    .set_gc  (set_gc),
    .cap_rw  (cap_rw),
    .rw_in   (byte_data[0]),
    .clr     (stat_rd),
    .hit_q   (addr_hit),
    .gc_q    (gen_call),
    .rw_q    (rw_bit)
  );
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input logic stat_rd,
  input logic match_pulse,
  input logic addr_hit,
  input logic gen_call,
  input logic rw_bit,
  input logic selected,
  input logic sr_event
);
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  p_pulse_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> (selected && addr_hit));

  p_gc_with_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gen_call |-> addr_hit);

  p_rw_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    selected |=> $stable(rw_bit));

  p_start_deselects_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !selected);

  p_sr_needs_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!selected && !start_i && !stop_i) |=> !sr_event);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (!addr_hit || match_pulse));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .stat_rd     (stat_rd),
  .match_pulse (match_pulse),
  .addr_hit    (addr_hit),
  .gen_call    (gen_call),
  .rw_bit      (rw_bit),
  .selected    (selected),
  .sr_event    (sr_event)
);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, byte_valid = 1'b0, stat_rd = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [9:0] own_addr = 10'h2A5;
  logic       mode_10b = 1'b0;
  logic       byte_ready, match_pulse, addr_hit, gen_call, rw_bit, selected, sr_event;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_addr_match uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .own_addr(own_addr), .mode_10b(mode_10b), .stat_rd(stat_rd),
    .match_pulse(match_pulse), .addr_hit(addr_hit), .gen_call(gen_call),
    .rw_bit(rw_bit), .selected(selected), .sr_event(sr_event)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic rd, input logic st);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = b; stat_rd = rd; start_i = st;
    @(negedge clk);
    byte_valid = 1'b0; stat_rd = 1'b0; start_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 selected", selected, 0);
    chk("R1 match_pulse", match_pulse, 0);
    chk("R1 addr_hit", addr_hit, 0);
    chk("R1 gen_call", gen_call, 0);
    chk("R1 rw_bit", rw_bit, 0);
    chk("R1 sr_event", sr_event, 0);
    chk("R10 byte_ready", byte_ready, 1);
    send(8'h4B, 0, 0);
    chk("R1 no match before start", match_pulse, 0);
    chk("R1 unselected before start", selected, 0);
  endtask

  task automatic t_short();
    mode_10b = 1'b0;
    pulse_start();
    send(8'h4B, 0, 0);
    chk("R2 match_pulse", match_pulse, 1);
    chk("R2 selected", selected, 1);
    chk("R2 addr_hit", addr_hit, 1);
    chk("R2 gen_call", gen_call, 0);
    chk("R6 rw_bit", rw_bit, 1);
    @(negedge clk);
    chk("R2 pulse one cycle", match_pulse, 0);
    send(8'h4A, 0, 0);
    chk("R10 no pulse on data", match_pulse, 0);
    chk("R6 rw held", rw_bit, 1);
    pulse_read();
    chk("R9 addr_hit cleared", addr_hit, 0);
    chk("R9 still selected", selected, 1);
  endtask

  task automatic t_gencall();
    mode_10b = 1'b1;
    pulse_start();
    send(8'h00, 0, 0);
    chk("R3 general call pulse", match_pulse, 1);
    chk("R3 gen_call", gen_call, 1);
    chk("R3 addr_hit", addr_hit, 1);
    chk("R6 rw from gc", rw_bit, 0);
    pulse_read();
    chk("R9 gen_call cleared", gen_call, 0);
    pulse_start();
    send(8'h01, 1, 0);
    chk("R9 set wins gen_call", gen_call, 1);
    chk("R9 set wins addr_hit", addr_hit, 1);
    chk("R3 start byte selects", selected, 1);
  endtask

  task automatic t_long();
    mode_10b = 1'b1;
    pulse_start();
    send(8'hF4, 0, 0);
    chk("R4 no pulse on header", match_pulse, 0);
    chk("R4 unselected on header", selected, 0);
    send(8'hA5, 0, 0);
    chk("R4 pulse on second byte", match_pulse, 1);
    chk("R4 selected", selected, 1);
    chk("R4 gen_call", gen_call, 0);
    chk("R6 rw from header", rw_bit, 0);
  endtask

  task automatic t_miss();
    mode_10b = 1'b1;
    pulse_start();
    send(8'hF4, 0, 0);
    send(8'hA6, 0, 0);
    chk("R5 long second mismatch", match_pulse, 0);
    chk("R5 long unselected", selected, 0);
    send(8'hA5, 0, 0);
    chk("R5 later byte ignored", match_pulse, 0);
    mode_10b = 1'b0;
    pulse_start();
    send(8'h10, 0, 0);
    chk("R5 short mismatch", selected, 0);
    send(8'h4B, 0, 0);
    chk("R5 short later byte ignored", match_pulse, 0);
  endtask

  task automatic t_events();
    mode_10b = 1'b0;
    pulse_start();
    send(8'h4A, 0, 0);
    chk("R2 selected before restart", selected, 1);
    pulse_start();
    chk("R8 sr_event on restart", sr_event, 1);
    chk("R7 restart deselects", selected, 0);
    @(negedge clk);
    chk("R8 sr_event one cycle", sr_event, 0);
    pulse_stop();
    chk("R8 no sr_event unselected", sr_event, 0);
    pulse_start();
    send(8'h4B, 0, 0);
    pulse_stop();
    chk("R8 sr_event on stop", sr_event, 1);
    chk("R8 stop deselects", selected, 0);
  endtask

  task automatic t_collide();
    mode_10b = 1'b0;
    send(8'h4B, 0, 1);
    chk("R11 byte with start dropped", match_pulse, 0);
    chk("R11 unselected", selected, 0);
    send(8'h4B, 0, 0);
    chk("R11 next byte is first", match_pulse, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_gencall();
    t_long();
    t_miss();
    t_events();
    t_collide();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule